// File: doc/BRIEF.md
# SPI Frame Master with Programmable Chip-Select Timing

This block is the transfer engine of an SPI master. Each accepted request produces one frame of 4 to 16 bits. The frame is shifted out on the serial data output, and a frame of the same length is shifted in from the serial data input at the same time. Clock polarity, clock phase and bit order are chosen for each frame. Three delays, counted in system clocks, set the frame envelope:

- the lead from chip-select assertion to the first serial clock edge;
- the trail from the last edge to chip-select release;
- the minimum deselected gap before the next frame can be accepted.

A client waits for `ready_o`, then presents the transmit word and the frame settings together with a one-cycle `start_i`. All settings are captured in that cycle. When chip select is released, `done_o` pulses for one cycle. In the same cycle `rx_data_o` takes the received word, right-justified, and holds it until the next frame completes. The serial clock half-period is `div_i + 1` system clocks, so the fastest serial clock is half the system clock.

Top module: `spi_frame_master`

## Requirements
- R1: The frame length is `len_i` bits, clamped to 4 when below 4 and to 16 when above 16. A frame of N bits makes exactly 2N serial clock edges, and `sck_o` ends the frame at its idle level.
- R2: With `cpha_i`=0, the first data bit is on `mosi_o` in the cycle chip select asserts. Data is sampled on odd-numbered edges (first edge = 1) and changes on even-numbered edges.
- R3: With `cpha_i`=1, data changes on odd-numbered edges (the first bit appears at edge 1) and is sampled on even-numbered edges.
- R4: While no frame is running, `sck_o` follows `cpol_i` (0 = idle low, 1 = idle high). While chip select is released, `sck_o` never toggles.
- R5: `lsb_first_i`=0 selects MSB first, meaning transmit bit N-1 goes first and the first received bit lands in `rx_data_o` bit N-1. `lsb_first_i`=1 selects LSB first, meaning bit 0 goes first and the first received bit lands in bit 0. `rx_data_o` bits N and above read 0.
- R6: Consecutive serial clock edges are `div_i + 1` system clocks apart.
- R7: The first serial clock edge comes `csc_dly_i + div_i + 2` system clocks after chip select falls.
- R8: Chip select rises `asc_dly_i + 1` system clocks after the last serial clock edge.
- R9: `ready_o` falls in the cycle chip select asserts. It rises again `idle_dly_i + 1` system clocks after chip select rises, and it is never high while chip select is low.
- R10: A `start_i` pulse while `ready_o` is low is ignored: no extra frame runs, and the running frame's data is unaffected.
- R11: `done_o` is a one-cycle pulse in the cycle chip select rises. From that cycle on, `rx_data_o` holds the received word.
- R12: During and after synchronous reset (`rst_n` low): `cs_n_o`=1, `ready_o`=1, `done_o`=0, `mosi_o`=0, `sck_o`=0 and `rx_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Frame request, taken only when ready_o is high |
| ready_o | output | 1 | Engine idle and able to accept a request |
| tx_data_i | input | 16 | Transmit word, right-justified |
| len_i | input | 5 | Frame length in bits (clamped to 4..16) |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase: 0 = sample on odd edges, 1 = sample on even edges |
| lsb_first_i | input | 1 | Bit order: 0 = MSB first, 1 = LSB first |
| div_i | input | 8 | Serial clock half-period minus one, in system clocks |
| csc_dly_i | input | 8 | Extra lead cycles from chip select to the first edge |
| asc_dly_i | input | 8 | Trail from the last edge to chip-select release, minus one |
| idle_dly_i | input | 8 | Deselected gap before ready, minus one |
| sck_o | output | 1 | Serial clock |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| rx_data_o | output | 16 | Received word, right-justified |
| done_o | output | 1 | One-cycle frame completion pulse |

## Verification
The bench runs a slave model with its own data word and measures every edge and chip-select change in system clocks. It targets these failure modes:

- **Phase.** An engine that swaps sampling and launching for one phase returns shifted or half-corrupted words in both directions.
- **Length clamping.** Lengths below 4 and above 16 are driven, and an unclamped engine emits the wrong number of edges and the wrong masked word.
- **Zero delays and the fastest divider.** These expose off-by-one errors in the lead, trail, gap and half-period counters as measured intervals that are one cycle short or long.
- **Start while busy.** A request during a running frame would, if accepted, show as a second chip-select assertion or a corrupted transmit word at the slave.

// File: rtl/spi_frame_pkg.sv
// Shared types for the SPI frame master.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_frame_pkg;

    // Frame sequencer phases, in the order a frame visits them.
    typedef enum logic [2:0] {
        ST_IDLE,   // deselected, accepting requests
        ST_LEAD,   // chip select low, waiting before the first edge
        ST_XFER,   // serial clock running
        ST_TRAIL,  // after the last edge, before chip-select release
        ST_GAP     // deselected, enforcing the minimum idle time
    } seq_state_e;

endpackage

// File: rtl/spi_frame_seq.sv
// Frame sequencer: runs the lead/transfer/trail/gap phases, counts the
// serial clock half-periods and edges, and drives chip select, ready and done.
// Assumes: MIN_BITS <= MAX_BITS < 2**LEN_W; the settings are captured on accept.
module spi_frame_seq
    import spi_frame_pkg::*;
#(
    parameter int MAX_BITS = 16,
    parameter int MIN_BITS = 4,
    parameter int TIME_W   = 8,
    parameter int LEN_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic              cpha_i,
    input  logic              lsb_first_i,
    input  logic [TIME_W-1:0] div_i,
    input  logic [TIME_W-1:0] csc_dly_i,
    input  logic [TIME_W-1:0] asc_dly_i,
    input  logic [TIME_W-1:0] idle_dly_i,
    output logic              ready_o,
    output logic              cs_n_o,
    output logic              done_o,
    output logic              load_stb_o,
    output logic              edge_stb_o,
    output logic              edge_odd_o,
    output logic              fin_stb_o,
    output logic [LEN_W-1:0]  len_in_o,
    output logic [LEN_W-1:0]  len_q_o,
    output logic              cpha_q_o,
    output logic              lsb_q_o
);
    localparam int EDGE_W = LEN_W + 1;

    seq_state_e        state;
    logic [TIME_W-1:0] cnt;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_nxt;
    logic [EDGE_W-1:0] last_edge;
    logic [TIME_W-1:0] div_q;
    logic [TIME_W-1:0] asc_q;
    logic [TIME_W-1:0] idle_q;

    // Clamp the requested frame length into the supported range.
    always_comb begin
        if (len_i < LEN_W'(MIN_BITS))      len_in_o = LEN_W'(MIN_BITS);
        else if (len_i > LEN_W'(MAX_BITS)) len_in_o = LEN_W'(MAX_BITS);
        else                               len_in_o = len_i;
    end

    // Edge bookkeeping and the strobes for the shift path and clock generator.
    always_comb begin
        edge_nxt   = edge_cnt + EDGE_W'(1);
        last_edge  = {len_q_o, 1'b0};
        ready_o    = (state == ST_IDLE);
        load_stb_o = (state == ST_IDLE) && start_i;
        edge_stb_o = (state == ST_XFER) && (cnt == '0);
        edge_odd_o = edge_nxt[0];
        fin_stb_o  = (state == ST_TRAIL) && (cnt == '0);
    end

    // Phase machine with a single shared down-counter for all timed phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            edge_cnt <= '0;
            cs_n_o   <= 1'b1;
            done_o   <= 1'b0;
            len_q_o  <= LEN_W'(MIN_BITS);
            cpha_q_o <= 1'b0;
            lsb_q_o  <= 1'b0;
            div_q    <= '0;
            asc_q    <= '0;
            idle_q   <= '0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_LEAD;
                        cnt      <= csc_dly_i;
                        edge_cnt <= '0;
                        cs_n_o   <= 1'b0;
                        len_q_o  <= len_in_o;
                        cpha_q_o <= cpha_i;
                        lsb_q_o  <= lsb_first_i;
                        div_q    <= div_i;
                        asc_q    <= asc_dly_i;
                        idle_q   <= idle_dly_i;
                    end
                end
                ST_LEAD: begin
                    if (cnt == '0) begin
                        state <= ST_XFER;
                        cnt   <= div_q;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_XFER: begin
                    if (cnt == '0) begin
                        edge_cnt <= edge_nxt;
                        if (edge_nxt == last_edge) begin
                            state <= ST_TRAIL;
                            cnt   <= asc_q;
                        end else begin
                            cnt <= div_q;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_TRAIL: begin
                    if (cnt == '0) begin
                        state  <= ST_GAP;
                        cnt    <= idle_q;
                        cs_n_o <= 1'b1;
                        done_o <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_GAP: begin
                    if (cnt == '0) state <= ST_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11: completion pulse lasts exactly one cycle.
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11: completion coincides with the chip-select release.
    a_r11_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && !$past(cs_n_o)));

    // R9: the engine never reports ready while a slave is selected.
    a_r9_ready_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> cs_n_o);

    // R1: the edge count never passes two edges per bit.
    a_r1_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (edge_cnt <= last_edge));

endmodule

// File: rtl/spi_sck_gen.sv
// Serial clock generator: holds the idle level taken from the polarity
// input while idle, and toggles once per edge strobe during a frame.
// Assumes: edge strobes arrive only while chip select is low.
module spi_sck_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic cs_n_i,
    input  logic cpol_i,
    input  logic edge_stb_i,
    output logic sck_o
);
    // Track the idle level when idle, toggle on each scheduled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)          sck_o <= 1'b0;
        else if (ready_i)    sck_o <= cpol_i;
        else if (edge_stb_i) sck_o <= ~sck_o;
    end

    // R4: no serial clock activity in the deselected gap.
    a_r4_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_i && cs_n_i) |-> $stable(sck_o));

endmodule

// File: rtl/spi_shift_path.sv
// Data path: launches transmit bits and captures receive bits on the
// edges picked by the clock phase, in the selected bit order.
// Assumes: edge strobes carry the parity of the edge about to occur.
module spi_shift_path #(
    parameter int MAX_BITS = 16,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_stb_i,
    input  logic                edge_stb_i,
    input  logic                edge_odd_i,
    input  logic                fin_stb_i,
    input  logic [LEN_W-1:0]    len_in_i,
    input  logic                cpha_in_i,
    input  logic                lsb_in_i,
    input  logic [MAX_BITS-1:0] tx_i,
    input  logic [LEN_W-1:0]    len_q_i,
    input  logic                cpha_q_i,
    input  logic                lsb_q_i,
    input  logic                miso_i,
    output logic                mosi_o,
    output logic [MAX_BITS-1:0] rx_data_o
);
    localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

    logic [MAX_BITS-1:0] tx_q;
    logic [MAX_BITS-1:0] rx_sr;
    logic [LEN_W-1:0]    tx_idx;
    logic [LEN_W-1:0]    rx_idx;
    logic                launch;

    // Map a serial position to a word bit under the chosen order.
    function automatic logic [IDX_W-1:0] bit_pos(input logic lsb,
                                                 input logic [LEN_W-1:0] n,
                                                 input logic [LEN_W-1:0] idx);
        logic [LEN_W-1:0] p;
        p = lsb ? idx : (n - idx - LEN_W'(1));
        return IDX_W'(p);
    endfunction

    // Launch edges are odd for phase 1 and even for phase 0.
    always_comb launch = cpha_q_i ? edge_odd_i : !edge_odd_i;

    // Shift both directions and publish the received word at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= '0;
            rx_sr     <= '0;
            tx_idx    <= '0;
            rx_idx    <= '0;
            mosi_o    <= 1'b0;
            rx_data_o <= '0;
        end else if (load_stb_i) begin
            tx_q   <= tx_i;
            rx_sr  <= '0;
            rx_idx <= '0;
            if (cpha_in_i) begin
                mosi_o <= 1'b0;
                tx_idx <= '0;
            end else begin
                mosi_o <= tx_i[bit_pos(lsb_in_i, len_in_i, '0)];
                tx_idx <= LEN_W'(1);
            end
        end else begin
            if (edge_stb_i) begin
                if (launch) begin
                    if (tx_idx < len_q_i) begin
                        mosi_o <= tx_q[bit_pos(lsb_q_i, len_q_i, tx_idx)];
                        tx_idx <= tx_idx + LEN_W'(1);
                    end
                end else if (rx_idx < len_q_i) begin
                    rx_sr[bit_pos(lsb_q_i, len_q_i, rx_idx)] <= miso_i;
                    rx_idx <= rx_idx + LEN_W'(1);
                end
            end
            if (fin_stb_i) begin
                rx_data_o <= rx_sr;
                mosi_o    <= 1'b0;
            end
        end
    end

    // R5: never launch more bits than the frame holds.
    a_r5_tx_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idx <= len_q_i);

    // R5: never capture more bits than the frame holds.
    a_r5_rx_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rx_idx <= len_q_i);

endmodule

// File: rtl/spi_frame_master.sv
// SPI master transfer engine, top level: joins the sequencer, the serial
// clock generator and the data path.
// Assumes: start_i is only honoured while ready_o is high.
module spi_frame_master #(
    parameter int MAX_BITS = 16,
    parameter int MIN_BITS = 4,
    parameter int TIME_W   = 8,
    parameter int LEN_W    = $clog2(MAX_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic                ready_o,
    input  logic [MAX_BITS-1:0] tx_data_i,
    input  logic [LEN_W-1:0]    len_i,
    input  logic                cpol_i,
    input  logic                cpha_i,
    input  logic                lsb_first_i,
    input  logic [TIME_W-1:0]   div_i,
    input  logic [TIME_W-1:0]   csc_dly_i,
    input  logic [TIME_W-1:0]   asc_dly_i,
    input  logic [TIME_W-1:0]   idle_dly_i,
    output logic                sck_o,
    output logic                cs_n_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic [MAX_BITS-1:0] rx_data_o,
    output logic                done_o
);
    logic             load_stb;
    logic             edge_stb;
    logic             edge_odd;
    logic             fin_stb;
    logic [LEN_W-1:0] len_in;
    logic [LEN_W-1:0] len_q;
    logic             cpha_q;
    logic             lsb_q;

    spi_frame_seq #(
        .MAX_BITS (MAX_BITS),
        .MIN_BITS (MIN_BITS),
        .TIME_W   (TIME_W),
        .LEN_W    (LEN_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .len_i       (len_i),
        .cpha_i      (cpha_i),
        .lsb_first_i (lsb_first_i),
        .div_i       (div_i),
        .csc_dly_i   (csc_dly_i),
        .asc_dly_i   (asc_dly_i),
        .idle_dly_i  (idle_dly_i),
        .ready_o     (ready_o),
        .cs_n_o      (cs_n_o),
        .done_o      (done_o),
        .load_stb_o  (load_stb),
        .edge_stb_o  (edge_stb),
        .edge_odd_o  (edge_odd),
        .fin_stb_o   (fin_stb),
        .len_in_o    (len_in),
        .len_q_o     (len_q),
        .cpha_q_o    (cpha_q),
        .lsb_q_o     (lsb_q)
    );

    spi_sck_gen u_sck (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (ready_o),
        .cs_n_i     (cs_n_o),
        .cpol_i     (cpol_i),
        .edge_stb_i (edge_stb),
        .sck_o      (sck_o)
    );

    spi_shift_path #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) u_path (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_stb_i (load_stb),
        .edge_stb_i (edge_stb),
        .edge_odd_i (edge_odd),
        .fin_stb_i  (fin_stb),
        .len_in_i   (len_in),
        .cpha_in_i  (cpha_i),
        .lsb_in_i   (lsb_first_i),
        .tx_i       (tx_data_i),
        .len_q_i    (len_q),
        .cpha_q_i   (cpha_q),
        .lsb_q_i    (lsb_q),
        .miso_i     (miso_i),
        .mosi_o     (mosi_o),
        .rx_data_o  (rx_data_o)
    );

endmodule

// File: tb/sim_spi_frame_master.sv
`timescale 1ns/1ps
// Bench: vector table of frame settings walked by one loop, then directed
// tests for reset and a start request while busy. A slave model and a
// cycle-stamped monitor run at the falling system clock edge.
module sim_spi_frame_master;

    typedef struct packed {
        logic [4:0]  len;
        logic        cpol;
        logic        cpha;
        logic        lsb;
        logic [7:0]  div;
        logic [7:0]  csc;
        logic [7:0]  asc;
        logic [7:0]  idle;
        logic [15:0] tx;
        logic [15:0] sl;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{5'd8,  1'b0, 1'b0, 1'b0, 8'd1, 8'd2, 8'd1, 8'd3, 16'h00A5, 16'h003C},
        '{5'd8,  1'b1, 1'b0, 1'b1, 8'd0, 8'd0, 8'd0, 8'd0, 16'h0096, 16'h00C3},
        '{5'd8,  1'b0, 1'b1, 1'b0, 8'd2, 8'd1, 8'd3, 8'd2, 16'h005A, 16'h0081},
        '{5'd8,  1'b1, 1'b1, 1'b1, 8'd1, 8'd3, 8'd2, 8'd1, 16'h001E, 16'h007B},
        '{5'd16, 1'b0, 1'b0, 1'b1, 8'd0, 8'd1, 8'd0, 8'd2, 16'hBEEF, 16'h1234},
        '{5'd4,  1'b1, 1'b1, 1'b0, 8'd3, 8'd0, 8'd4, 8'd0, 16'h000A, 16'h0005},
        '{5'd12, 1'b0, 1'b1, 1'b1, 8'd1, 8'd5, 8'd1, 8'd4, 16'h0ABC, 16'h0F0F},
        '{5'd2,  1'b0, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 16'hFFF6, 16'h000C},
        '{5'd20, 1'b1, 1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd1, 16'h8001, 16'h7FFE}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] tx_data_i = '0;
    logic [4:0]  len_i = 5'd8;
    logic        cpol_i = 1'b0;
    logic        cpha_i = 1'b0;
    logic        lsb_first_i = 1'b0;
    logic [7:0]  div_i = '0;
    logic [7:0]  csc_dly_i = '0;
    logic [7:0]  asc_dly_i = '0;
    logic [7:0]  idle_dly_i = '0;
    logic        miso_i = 1'b0;
    logic        ready_o, sck_o, cs_n_o, mosi_o, done_o;
    logic [15:0] rx_data_o;

    int checks = 0;
    int errors = 0;

    // Monitor and slave state.
    int          cyc = 0;
    int          t_csf, t_first, t_second, t_last, t_csr, t_rdy;
    int          edges, frames, dones;
    int          s_j, s_k;
    logic [15:0] slave_got;
    logic        sck_at_csf, mosi_at_csf, done_at_rise;
    bit          rdy_seen;
    int          cur_n = 8;
    logic        cur_cpha = 1'b0;
    logic        cur_lsb = 1'b0;
    logic [15:0] cur_sl = '0;

    always #2 clk = ~clk;

    spi_frame_master u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ready_o     (ready_o),
        .tx_data_i   (tx_data_i),
        .len_i       (len_i),
        .cpol_i      (cpol_i),
        .cpha_i      (cpha_i),
        .lsb_first_i (lsb_first_i),
        .div_i       (div_i),
        .csc_dly_i   (csc_dly_i),
        .asc_dly_i   (asc_dly_i),
        .idle_dly_i  (idle_dly_i),
        .sck_o       (sck_o),
        .cs_n_o      (cs_n_o),
        .mosi_o      (mosi_o),
        .miso_i      (miso_i),
        .rx_data_o   (rx_data_o),
        .done_o      (done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Word bit carried by serial position j under the current order.
    function automatic int word_pos(input int j);
        return cur_lsb ? j : (cur_n - 1 - j);
    endfunction

    // Monitor plus slave model, evaluated away from the active edge.
    initial begin
        logic prev_cs, prev_sck, prev_rdy;
        prev_cs = 1'b1; prev_sck = 1'b0; prev_rdy = 1'b1;
        frames = 0; dones = 0; edges = 0; s_j = 0; s_k = 0; slave_got = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (prev_cs && !cs_n_o) begin
                    t_csf = cyc; frames++; edges = 0; s_k = 0; slave_got = '0;
                    sck_at_csf = sck_o; mosi_at_csf = mosi_o;
                    if (!cur_cpha) begin
                        miso_i = cur_sl[4'(word_pos(0))]; s_j = 1;
                    end else begin
                        miso_i = 1'b0; s_j = 0;
                    end
                end
                if (!prev_cs && cs_n_o) begin
                    t_csr = cyc; done_at_rise = done_o;
                end
                if (done_o) dones++;
                if ((sck_o !== prev_sck) && !cs_n_o) begin
                    edges++;
                    if (edges == 1) t_first = cyc;
                    if (edges == 2) t_second = cyc;
                    t_last = cyc;
                    if (cur_cpha ? (edges % 2 == 0) : (edges % 2 == 1)) begin
                        if (s_k < cur_n) slave_got[4'(word_pos(s_k))] = mosi_o;
                        s_k++;
                    end else begin
                        if (s_j < cur_n) miso_i = cur_sl[4'(word_pos(s_j))];
                        s_j++;
                    end
                end
                if (!prev_rdy && ready_o) begin
                    t_rdy = cyc; rdy_seen = 1'b1;
                end
            end
            prev_cs = cs_n_o; prev_sck = sck_o; prev_rdy = ready_o;
        end
    end

    // Apply settings, issue one request, and wait for the engine to be ready again.
    task automatic run_frame(input vec_t v, input bit poke_busy);
        int n;
        int mask;
        int frames0;
        n = (int'(v.len) < 4) ? 4 : ((int'(v.len) > 16) ? 16 : int'(v.len));
        mask = (1 << n) - 1;
        while (!ready_o) @(negedge clk);
        tx_data_i = v.tx; len_i = v.len; cpol_i = v.cpol; cpha_i = v.cpha;
        lsb_first_i = v.lsb; div_i = v.div; csc_dly_i = v.csc;
        asc_dly_i = v.asc; idle_dly_i = v.idle;
        cur_n = n; cur_cpha = v.cpha; cur_lsb = v.lsb; cur_sl = v.sl;
        repeat (2) @(negedge clk);
        chk(sck_o == v.cpol, "R4 idle level", int'(sck_o), int'(v.cpol));
        frames0 = frames;
        rdy_seen = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!ready_o && !cs_n_o, "R9 ready low at select", int'(ready_o), 0);
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            tx_data_i = 16'h0000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (!rdy_seen) @(negedge clk);
        chk(edges == 2 * n, "R1 edge count", edges, 2 * n);
        chk(sck_o == v.cpol, "R1 sck back at idle", int'(sck_o), int'(v.cpol));
        chk(sck_at_csf == v.cpol, "R4 level at select", int'(sck_at_csf), int'(v.cpol));
        if (!v.cpha)
            chk(mosi_at_csf == v.tx[4'(v.lsb ? 0 : n - 1)], "R2 first bit at select",
                int'(mosi_at_csf), int'(v.tx[4'(v.lsb ? 0 : n - 1)]));
        chk(int'(slave_got) == (int'(v.tx) & mask), v.cpha ? "R3 slave received" : "R2 slave received",
            int'(slave_got), int'(v.tx) & mask);
        chk(int'(rx_data_o) == (int'(v.sl) & mask), "R5 master received",
            int'(rx_data_o), int'(v.sl) & mask);
        chk(t_first - t_csf == int'(v.csc) + int'(v.div) + 2, "R7 lead time",
            t_first - t_csf, int'(v.csc) + int'(v.div) + 2);
        chk(t_second - t_first == int'(v.div) + 1, "R6 half period",
            t_second - t_first, int'(v.div) + 1);
        chk(t_csr - t_last == int'(v.asc) + 1, "R8 trail time",
            t_csr - t_last, int'(v.asc) + 1);
        chk(t_rdy - t_csr == int'(v.idle) + 1, "R9 idle gap",
            t_rdy - t_csr, int'(v.idle) + 1);
        chk(done_at_rise == 1'b1, "R11 done at release", int'(done_at_rise), 1);
        if (poke_busy)
            chk(frames - frames0 == 1, "R10 single frame", frames - frames0, 1);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int dones0;
        // R12: reset state.
        repeat (3) @(negedge clk);
        chk(cs_n_o == 1'b1, "R12 cs_n in reset", int'(cs_n_o), 1);
        chk(ready_o == 1'b1, "R12 ready in reset", int'(ready_o), 1);
        chk(done_o == 1'b0, "R12 done in reset", int'(done_o), 0);
        chk(mosi_o == 1'b0 && sck_o == 1'b0, "R12 serial lines in reset",
            int'({mosi_o, sck_o}), 0);
        chk(rx_data_o == 16'h0000, "R12 rx_data in reset", int'(rx_data_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            dones0 = dones;
            run_frame(VECS[i], 1'b0);
            chk(dones - dones0 == 1, "R11 one done per frame", dones - dones0, 1);
        end

        // R10: start requests during a frame are ignored.
        run_frame(VECS[0], 1'b1);
        repeat (6) @(negedge clk);
        chk(cs_n_o == 1'b1, "R10 no late frame", int'(cs_n_o), 1);
        chk(int'(rx_data_o) == int'(VECS[0].sl), "R11 rx_data held",
            int'(rx_data_o), int'(VECS[0].sl));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule